// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns an active-low external interrupt pin and a software-interrupt request into one interrupt request for a small 8-bit CPU core. The pin is synchronised into the core clock. A configuration bit then chooses how it triggers. In falling-edge mode an edge or a short low pulse is caught in a latch. The latch keeps the event until the CPU services it. In low-level mode the request follows the pin with no memory.

The external request is gated by the CPU's global interrupt mask. A software interrupt is not gated by the mask. When the two compete, they are ordered by when the software interrupt was fetched. Once a source is accepted, the block raises a pending flag and presents the 16-bit address of the winning vector's high byte. The CPU's acknowledge pulse marks the start of servicing and retires the accepted source. A byte-wide register port gives read and write access to the option register that holds the trigger-mode bit.

Top module: `irq_req_ctrl`

## Requirements
- R1: After reset `int_pending` is 0, `int_vector` is 16'h0000, and the option register reads 8'h40, which puts trigger-mode bit 7 at 0 (level mode).
- R2: The option register sits at address 8'h1D: a write there updates it and a read returns it. A read from any other address returns 8'h00, and a write to any other address leaves the option register unchanged.
- R3: With option bit 7 = 0 (level mode) and the mask clear, the pin held low makes `int_pending` rise 3 clock edges after the pin falls. A low level that ends while the mask is set leaves nothing pending.
- R4: With option bit 7 = 1 (edge mode) and the mask clear, a falling edge makes `int_pending` rise 4 clock edges after the pin falls. A low pulse of a single clock cycle is enough.
- R5: While `cpu_mask` = 1, no external request is accepted. An edge that arrives while masked is kept, and it is accepted on the first clock edge after the mask clears.
- R6: An acknowledge of an accepted external request clears the edge latch, so a pin that stays low raises no further request. A new falling edge after the acknowledge is latched again.
- R7: An accepted external request presents vector 16'h3FFA.
- R8: A `swi_req` pulse is accepted whatever the value of `cpu_mask`, and it presents vector 16'h3FFC.
- R9: With the mask clear, an external request that is already pending when `swi_req` is sampled is serviced before the software interrupt. An external request that becomes pending in the same cycle or later is serviced after the software interrupt.
- R10: `int_vector` and `int_pending` stay unchanged from the cycle a source is accepted until the `int_ack` pulse. After the acknowledge, `int_pending` drops on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low external interrupt pin |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| cpu_mask | input | 1 | CPU global interrupt mask bit (1 = maskable interrupts blocked) |
| swi_req | input | 1 | One-cycle pulse: a software interrupt instruction was fetched |
| int_ack | input | 1 | One-cycle pulse: the CPU starts servicing the pending interrupt |
| int_pending | output | 1 | An interrupt source has been accepted and awaits acknowledge |
| int_vector | output | 16 | Address of the vector high byte for the accepted source |

## Verification
On every cycle, the assertions check four things. The vector and pending flag hold steady until acknowledge. An external source is only ever accepted from a cycle with the mask clear. A caught edge survives until it is acknowledged. Level mode never leaves the latch set. Only the bench scenarios can show the exact request latency of each trigger mode, the register decode, and the release of a masked edge. They also show how a software interrupt is ordered against external events that arrive before it and with it.

// File: rtl/irqc_pkg.sv
// Package: shared types and constants for the external interrupt request controller.
// Assumes vectors are 16-bit addresses of the vector high byte.
package irqc_pkg;
    typedef enum logic [0:0] {
        SRC_EXT = 1'b0,
        SRC_SWI = 1'b1
    } irq_src_e;

    localparam logic [15:0] EXT_VECTOR = 16'h3FFA;
    localparam logic [15:0] SWI_VECTOR = 16'h3FFC;
    localparam logic [15:0] IDLE_VECTOR = 16'h0000;
endpackage

// File: rtl/irqc_pin_sync.sv
// Module: synchronises the asynchronous active-low pin and detects falling edges.
// Assumes STAGES >= 2; the edge compares the last synchronised sample with the one before.
module irqc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low,
    output logic pin_fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchroniser chain; the idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], pin_n};
    end

    // Keep the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign pin_low  = ~sync_q[STAGES-1];
    assign pin_fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irqc_capture.sv
// Module: forms the external request from the synchronised pin.
// Edge mode keeps each falling edge in a latch until it is cleared; level mode follows the pin.
// Assumes clr is a single-cycle pulse that marks the start of servicing of the external source.
module irqc_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic pin_low,
    input  logic pin_fall,
    input  logic clr,
    output logic ext_req
);
    logic latch_q;

    // Edge latch: a new edge wins over a clear in the same cycle; level mode keeps it empty.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= 1'b0;
        else if (!edge_mode) latch_q <= 1'b0;
        else if (pin_fall)   latch_q <= 1'b1;
        else if (clr)        latch_q <= 1'b0;
    end

    assign ext_req = edge_mode ? latch_q : pin_low;

    // R5/R6: a caught edge is kept until it is cleared or the mode leaves edge.
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && latch_q && !clr) |=> (latch_q || !edge_mode));

    // R3: level mode never leaves an event stored.
    assert_level_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!edge_mode) |-> !latch_q);
endmodule

// File: rtl/irqc_arbiter.sv
// Module: chooses between the external and the software source, holds the choice and its
// vector until acknowledge. Assumes swi_req and int_ack are single-cycle pulses.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_req,
    input  logic             cpu_mask,
    input  logic             swi_req,
    input  logic             int_ack,
    output logic             ext_clr,
    output logic             int_pending,
    output logic [VEC_W-1:0] int_vector
);
    logic     swi_pend_q;
    logic     ext_first_q;
    logic     sel_valid_q;
    irq_src_e sel_src_q;
    logic     ext_elig;
    logic     take_ext;
    logic     take_swi;
    logic     ack_ext;
    logic     ack_swi;

    assign ext_elig = ext_req & ~cpu_mask;
    assign take_ext = ~sel_valid_q & ext_elig & (~swi_pend_q | ext_first_q);
    assign take_swi = ~sel_valid_q & swi_pend_q & ~take_ext;
    assign ack_ext  = int_ack & sel_valid_q & (sel_src_q == SRC_EXT);
    assign ack_swi  = int_ack & sel_valid_q & (sel_src_q == SRC_SWI);
    assign ext_clr  = ack_ext;

    // Record a fetched software interrupt until it is serviced.
    always_ff @(posedge clk) begin
        if (!rst_n)       swi_pend_q <= 1'b0;
        else if (swi_req) swi_pend_q <= 1'b1;
        else if (ack_swi) swi_pend_q <= 1'b0;
    end

    // Note whether an enabled external request was already waiting when the software one came.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ext_first_q <= 1'b0;
        else if (swi_req)           ext_first_q <= ext_elig;
        else if (ack_ext || ack_swi) ext_first_q <= 1'b0;
    end

    // Accept one source and hold it until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_q <= 1'b0;
            sel_src_q   <= SRC_EXT;
        end else if (sel_valid_q) begin
            if (int_ack) sel_valid_q <= 1'b0;
        end else if (take_ext) begin
            sel_valid_q <= 1'b1;
            sel_src_q   <= SRC_EXT;
        end else if (take_swi) begin
            sel_valid_q <= 1'b1;
            sel_src_q   <= SRC_SWI;
        end
    end

    assign int_pending = sel_valid_q;

    // Present the vector of the held source; idle shows zero.
    always_comb begin
        if (!sel_valid_q)             int_vector = VEC_W'(IDLE_VECTOR);
        else if (sel_src_q == SRC_SWI) int_vector = VEC_W'(SWI_VECTOR);
        else                          int_vector = VEC_W'(EXT_VECTOR);
    end

    // R10: the accepted vector does not move until acknowledge.
    assert_vector_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pending && !int_ack) |=> (int_pending && $stable(int_vector)));

    // R10: acknowledge retires the pending source on the next edge.
    assert_ack_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pending && int_ack) |=> !int_pending);

    // R5: an external source is only accepted from a cycle with the mask clear.
    assert_ext_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_pending ##1 (int_pending && int_vector == VEC_W'(EXT_VECTOR))) |-> !$past(cpu_mask));

    // R8: the vector is always one of the known values.
    assert_vector_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_pending |-> (int_vector == VEC_W'(EXT_VECTOR) || int_vector == VEC_W'(SWI_VECTOR)));
endmodule

// File: rtl/irq_req_ctrl.sv
// Module: top of the external interrupt request controller. Holds the option register,
// synchronises the pin, forms the external request and arbitrates against the software request.
// Assumes a single register write port with combinational read data.
module irq_req_ctrl #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int          VEC_W     = 16,
    parameter int          SYNC_STG  = 2,
    parameter int          EDGE_BIT  = 7,
    parameter logic [7:0]  OPT_ADDR  = 8'h1D,
    parameter logic [7:0]  OPT_RESET = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              cpu_mask,
    input  logic              swi_req,
    input  logic              int_ack,
    output logic              int_pending,
    output logic [VEC_W-1:0]  int_vector
);
    localparam logic [ADDR_W-1:0] OPT_SEL = ADDR_W'(OPT_ADDR);

    logic [DATA_W-1:0] opt_q;
    logic              opt_hit;
    logic              pin_low;
    logic              pin_fall;
    logic              ext_req;
    logic              ext_clr;

    assign opt_hit = (cfg_addr == OPT_SEL);

    // Option register: written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)                   opt_q <= DATA_W'(OPT_RESET);
        else if (cfg_wr_en && opt_hit) opt_q <= cfg_wdata;
    end

    assign cfg_rdata = opt_hit ? opt_q : '0;

    irqc_pin_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (irq_pin_n),
        .pin_low  (pin_low),
        .pin_fall (pin_fall)
    );

    irqc_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (opt_q[EDGE_BIT]),
        .pin_low   (pin_low),
        .pin_fall  (pin_fall),
        .clr       (ext_clr),
        .ext_req   (ext_req)
    );

    irqc_arbiter #(.VEC_W(VEC_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_req     (ext_req),
        .cpu_mask    (cpu_mask),
        .swi_req     (swi_req),
        .int_ack     (int_ack),
        .ext_clr     (ext_clr),
        .int_pending (int_pending),
        .int_vector  (int_vector)
    );

    // R2: a write to another address leaves the option register alone.
    assert_opt_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !opt_hit) |=> $stable(opt_q));
endmodule

// File: tb/tb_irq_req_ctrl.sv
module tb_irq_req_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_pin_n = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        cpu_mask = 1'b1;
    logic        swi_req = 1'b0;
    logic        int_ack = 1'b0;
    logic        int_pending;
    logic [15:0] int_vector;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    irq_req_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_mask(cpu_mask), .swi_req(swi_req), .int_ack(int_ack),
        .int_pending(int_pending), .int_vector(int_vector)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_req(input string req, input logic pend, input logic [15:0] vec);
        check(req, "int_pending", {31'd0, int_pending}, {31'd0, pend});
        check(req, "int_vector", {16'd0, int_vector}, {16'd0, vec});
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ack(input logic mask_after);
        int_ack = 1'b1; cpu_mask = mask_after;
        tick(1);
        int_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_pin_n = 1'b1; cpu_mask = 1'b1; swi_req = 1'b0; int_ack = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        cfg_addr = 8'h1D;
        tick(1);
        check_req("R1", 1'b0, 16'h0000);
        check("R1", "option reset", {24'd0, cfg_rdata}, 32'h40);
    endtask

    task automatic t_regs();
        wr_reg(8'h1D, 8'hC5);
        cfg_addr = 8'h1D; tick(1);
        check("R2", "option readback", {24'd0, cfg_rdata}, 32'hC5);
        wr_reg(8'h1C, 8'h00);
        cfg_addr = 8'h1C; tick(1);
        check("R2", "other address reads zero", {24'd0, cfg_rdata}, 32'h0);
        cfg_addr = 8'h1D; tick(1);
        check("R2", "option unchanged by other write", {24'd0, cfg_rdata}, 32'hC5);
        wr_reg(8'h1D, 8'h40);
    endtask

    task automatic t_level();
        do_reset();
        cpu_mask = 1'b0;
        irq_pin_n = 1'b0;
        tick(2);
        check_req("R3", 1'b0, 16'h0000);
        tick(1);
        check_req("R3", 1'b1, 16'h3FFA);
        tick(3);
        check_req("R10", 1'b1, 16'h3FFA);
        ack(1'b1);
        irq_pin_n = 1'b1;
        check_req("R10", 1'b0, 16'h0000);
        // level low while masked, released before unmask: nothing remains
        irq_pin_n = 1'b0; tick(5);
        irq_pin_n = 1'b1; tick(4);
        cpu_mask = 1'b0; tick(3);
        check_req("R3", 1'b0, 16'h0000);
    endtask

    task automatic t_edge();
        do_reset();
        wr_reg(8'h1D, 8'hC0);
        cpu_mask = 1'b0;
        irq_pin_n = 1'b0; tick(1);
        irq_pin_n = 1'b1;
        tick(2);
        check_req("R4", 1'b0, 16'h0000);
        tick(1);
        check_req("R4", 1'b1, 16'h3FFA);
        check_req("R7", 1'b1, 16'h3FFA);
        ack(1'b0);
        tick(3);
        check_req("R6", 1'b0, 16'h0000);
    endtask

    task automatic t_edge_hold_low();
        do_reset();
        wr_reg(8'h1D, 8'h80);
        cpu_mask = 1'b0;
        irq_pin_n = 1'b0;
        tick(4);
        check_req("R4", 1'b1, 16'h3FFA);
        ack(1'b0);
        tick(5);
        check_req("R6", 1'b0, 16'h0000);
        irq_pin_n = 1'b1; tick(3);
        irq_pin_n = 1'b0; tick(4);
        check_req("R6", 1'b1, 16'h3FFA);
        ack(1'b1);
        irq_pin_n = 1'b1;
    endtask

    task automatic t_masked_edge();
        do_reset();
        wr_reg(8'h1D, 8'h80);
        cpu_mask = 1'b1;
        irq_pin_n = 1'b0; tick(1);
        irq_pin_n = 1'b1;
        tick(10);
        check_req("R5", 1'b0, 16'h0000);
        cpu_mask = 1'b0;
        tick(1);
        check_req("R5", 1'b1, 16'h3FFA);
        ack(1'b1);
    endtask

    task automatic t_swi_masked();
        do_reset();
        cpu_mask = 1'b1;
        swi_req = 1'b1; tick(1);
        swi_req = 1'b0;
        tick(1);
        check_req("R8", 1'b1, 16'h3FFC);
        ack(1'b1);
        check_req("R8", 1'b0, 16'h0000);
        tick(3);
        check_req("R8", 1'b0, 16'h0000);
    endtask

    task automatic t_order_ext_first();
        do_reset();
        wr_reg(8'h1D, 8'h80);
        cpu_mask = 1'b0;
        irq_pin_n = 1'b0; tick(1);
        irq_pin_n = 1'b1;
        tick(3);
        check_req("R9", 1'b1, 16'h3FFA);
        swi_req = 1'b1; tick(1);
        swi_req = 1'b0; tick(2);
        check_req("R10", 1'b1, 16'h3FFA);
        ack(1'b1);
        check_req("R9", 1'b0, 16'h0000);
        tick(1);
        check_req("R9", 1'b1, 16'h3FFC);
        ack(1'b1);
        tick(2);
        check_req("R9", 1'b0, 16'h0000);
    endtask

    task automatic t_order_swi_first();
        do_reset();
        wr_reg(8'h1D, 8'h80);
        cpu_mask = 1'b0;
        irq_pin_n = 1'b0; tick(1);
        irq_pin_n = 1'b1; tick(1);
        swi_req = 1'b1; tick(1);
        swi_req = 1'b0;
        tick(1);
        check_req("R9", 1'b1, 16'h3FFC);
        ack(1'b1);
        tick(3);
        check_req("R5", 1'b0, 16'h0000);
        cpu_mask = 1'b0;
        tick(1);
        check_req("R9", 1'b1, 16'h3FFA);
        ack(1'b1);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_level();
        t_edge();
        t_edge_hold_low();
        t_masked_edge();
        t_swi_masked();
        t_order_ext_first();
        t_order_swi_first();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule